// File: doc/BRIEF.md
# Framed serial register-access slave

This block is a serial-port slave that gives a host access to a bank of 16-bit registers through fixed 16-bit transfers. The host clocks in one frame per chip-select pulse, most significant bit first. The top bit of a frame selects write (1) or read (0). The next seven bits carry a byte address, and the low eight bits carry the byte to store. A write updates one byte. A read only names a register. That register's full 16-bit value is shifted out during the next frame, while the host shifts in its next command.

The register storage sits outside the block. The block presents a register index and samples the word that comes back. Writes leave the block as a one-cycle byte strobe with its address and data. All serial inputs pass through a synchronizer into the system clock, and clock edges are found in that domain. As a result, the serial clock must be several times slower than the system clock. A frame whose clock count is not a whole multiple of 16 raises a sticky error flag. That frame is also discarded.

Top module: `spi16_regslave`

## Requirements
- R1: A committed frame with bit 15 = 1 produces exactly one `wr_stb` pulse, carrying byte address bits [14:8] on `wr_addr` and data bits [7:0] on `wr_data`.
- R2: A read of byte address A presents register index A>>1 on `rd_idx`, so the even address (low byte) and the odd address (high byte) of a pair return the same 16-bit word.
- R3: After a committed frame with bit 15 = 0, the next frame shifts out the selected 16-bit register value on `spi_dout`, MSB first, while a new command is shifted in.
- R4: In the frame that follows a write frame, `spi_dout` drives all zeros.
- R5: `spi_dout` is high impedance whenever `spi_cs_n` is high.
- R6: Clock polarity 1, phase 1: `spi_din` is sampled on rising `spi_sclk` edges, and `spi_dout` changes only on falling edges or on the start of a frame.
- R7: A frame with a nonzero clock count that is not a multiple of 16 sets `err_flag`. The flag stays set until `err_clr` is pulsed.
- R8: A frame with a bad clock count produces no write strobe, and it cancels any pending read, so the next frame shifts out zeros.
- R9: A frame of 32 clocks is accepted, and only its last 16 bits are decoded.
- R10: Byte addresses at or above 2*NUM_REGS (48 by default) produce no write strobe and read back as zero.
- R11: After reset, `err_flag` is 0, no strobe has occurred, and the first frame shifts out zeros.
- R12: A chip-select pulse with no clocks changes nothing: there is no strobe, no error, and a pending read survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_din | input | 1 | Serial data from host |
| spi_dout | output | 1 | Serial data to host, high-Z while deselected |
| rd_idx | output | ADDR_W-1 | Index of register to be read |
| rd_data | input | 2*BYTE_W | Word of the indexed register |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | BYTE_W | Byte to write |
| err_clr | input | 1 | Clears the frame-error flag |
| err_flag | output | 1 | Sticky frame-length error |

## Verification
Every cycle, the embedded properties check several rules. Strobes are single-cycle, follow only a clean frame end, and never target an unmapped address. A bad frame end always leaves the error flag set and the pending read dropped, and the flag holds until it is cleared. The outgoing shift register moves only on a falling clock or at frame start. The directed scenarios cover what a property cannot see end to end. These are the serial data seen by the host one frame later, the byte-pair aliasing of reads, the frames of 12 and 32 clocks, the empty chip-select pulse, and the high-impedance line.

// File: rtl/spi16_pkg.sv
package spi16_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } spi16_op_e;

   localparam int DEF_ADDR_W   = 7;
   localparam int DEF_BYTE_W   = 8;
   localparam int DEF_NUM_REGS = 24;
   localparam int DEF_SYNC     = 2;
endpackage

// File: rtl/spi16_sync.sv
module spi16_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_chk
         $error("spi16_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi16_framer.sv
module spi16_framer #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csn_s,
   input  logic               sclk_s,
   input  logic               din_s,
   output logic               cs_fall,
   output logic               sclk_fall,
   output logic               clk_seen,
   output logic               end_ok,
   output logic               end_bad,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

   logic             csn_d, sclk_d;
   logic             sclk_rise, cs_rise;
   logic [CNT_W-1:0] bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_d  <= 1'b1;
         sclk_d <= 1'b1;
      end else begin
         csn_d  <= csn_s;
         sclk_d <= sclk_s;
      end
   end

   assign cs_fall   = csn_d & ~csn_s;
   assign cs_rise   = ~csn_d & csn_s;
   assign sclk_rise = ~csn_s & ~sclk_d & sclk_s;
   assign sclk_fall = ~csn_s & sclk_d & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         clk_seen <= 1'b0;
         rx_word  <= '0;
      end else if (cs_fall) begin
         bit_cnt  <= '0;
         clk_seen <= 1'b0;
      end else if (sclk_rise) begin
         rx_word  <= {rx_word[FRAME_W-2:0], din_s};
         clk_seen <= 1'b1;
         bit_cnt  <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
      end
   end

   assign end_ok  = cs_rise & clk_seen & (bit_cnt == '0);
   assign end_bad = cs_rise & clk_seen & (bit_cnt != '0);

   p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(rx_word));
endmodule

// File: rtl/spi16_cmd.sv
module spi16_cmd
   import spi16_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int BYTE_W   = 8,
   parameter int NUM_REGS = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               end_ok,
   input  logic               end_bad,
   input  logic [ADDR_W+BYTE_W:0] rx_word,
   input  logic               err_clr,
   output logic               wr_stb,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0]  wr_data,
   output logic               rd_pend,
   output logic [ADDR_W-2:0]  rd_idx,
   output logic               err_flag
);
   localparam int FRAME_W = 1 + ADDR_W + BYTE_W;
   localparam logic [ADDR_W:0] MAP_LIM = (ADDR_W+1)'(2 * NUM_REGS);

   spi16_op_e          op;
   logic [ADDR_W-1:0]  f_addr;
   logic [BYTE_W-1:0]  f_data;
   logic               mapped;

   assign op     = spi16_op_e'(rx_word[FRAME_W-1]);
   assign f_addr = rx_word[FRAME_W-2:BYTE_W];
   assign f_data = rx_word[BYTE_W-1:0];
   assign mapped = {1'b0, f_addr} < MAP_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         rd_pend <= 1'b0;
         rd_idx  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (end_bad) begin
            rd_pend <= 1'b0;
         end else if (end_ok) begin
            if (op == OP_WRITE) begin
               wr_stb  <= mapped;
               wr_addr <= f_addr;
               wr_data <= f_data;
               rd_pend <= 1'b0;
            end else begin
               rd_pend <= mapped;
               rd_idx  <= f_addr[ADDR_W-1:1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_flag <= 1'b0;
      else if (end_bad) err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
   end

   p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   p_stb_after_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(end_ok));
   p_stb_mapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ({1'b0, wr_addr} < MAP_LIM));
   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      end_bad |=> err_flag);
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);
   p_bad_drops_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      end_bad |=> !rd_pend);
endmodule

// File: rtl/spi16_regslave.sv
module spi16_regslave
   import spi16_pkg::*;
#(
   parameter int ADDR_W   = DEF_ADDR_W,
   parameter int BYTE_W   = DEF_BYTE_W,
   parameter int NUM_REGS = DEF_NUM_REGS,
   parameter int SYNC     = DEF_SYNC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spi_cs_n,
   input  logic                spi_sclk,
   input  logic                spi_din,
   output logic                spi_dout,
   output logic [ADDR_W-2:0]   rd_idx,
   input  logic [2*BYTE_W-1:0] rd_data,
   output logic                wr_stb,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [BYTE_W-1:0]   wr_data,
   input  logic                err_clr,
   output logic                err_flag
);
   localparam int FRAME_W = 1 + ADDR_W + BYTE_W;
   localparam int REG_W   = 2 * BYTE_W;

   generate
      if (FRAME_W != REG_W) begin : g_chk_w
         $error("spi16_regslave: frame width must equal register width");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << (ADDR_W - 1))) begin : g_chk_n
         $error("spi16_regslave: NUM_REGS out of range for ADDR_W");
      end
   endgenerate

   logic               csn_s, sclk_s, din_s;
   logic               cs_fall, sclk_fall, clk_seen, end_ok, end_bad;
   logic               rd_pend;
   logic [FRAME_W-1:0] rx_word;
   logic [FRAME_W-1:0] tx_q;

   spi16_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(csn_s));
   spi16_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
   spi16_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(spi_din), .q(din_s));

   spi16_framer #(.FRAME_W(FRAME_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sclk_s(sclk_s), .din_s(din_s),
      .cs_fall(cs_fall), .sclk_fall(sclk_fall), .clk_seen(clk_seen),
      .end_ok(end_ok), .end_bad(end_bad), .rx_word(rx_word));

   spi16_cmd #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS)) u_cmd (
      .clk(clk), .rst_n(rst_n), .end_ok(end_ok), .end_bad(end_bad),
      .rx_word(rx_word), .err_clr(err_clr), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_pend(rd_pend),
      .rd_idx(rd_idx), .err_flag(err_flag));

   // Outgoing shifter: loaded at frame start, advanced on falling edges
   // once the first rising edge of the frame has sampled its bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      tx_q <= '0;
      else if (cs_fall)                tx_q <= rd_pend ? rd_data : '0;
      else if (sclk_fall && clk_seen)  tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
   end

   assign spi_dout = spi_cs_n ? 1'bz : tx_q[FRAME_W-1];

   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk_fall || cs_fall) |=> $stable(tx_q));
   p_tx_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && !rd_pend) |=> (tx_q == '0));
endmodule

// File: tb/spi16_regslave_tb_top.sv
`timescale 1ns/1ps
module spi16_regslave_tb_top;
   localparam int NREG = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs_n = 1'b1, spi_sclk = 1'b1, spi_din = 1'b0;
   wire         spi_dout;
   logic [5:0]  rd_idx;
   logic [15:0] rd_data;
   logic        wr_stb;
   logic [6:0]  wr_addr;
   logic [7:0]  wr_data;
   logic        err_clr = 1'b0;
   logic        err_flag;

   int n_chk = 0, n_bad = 0;
   int stb_cnt = 0;
   logic [6:0]  last_addr;
   logic [7:0]  last_data;
   logic [15:0] mem [NREG];
   logic [31:0] got;

   always #2 clk = ~clk;

   spi16_regslave dut_i (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_din(spi_din), .spi_dout(spi_dout), .rd_idx(rd_idx),
      .rd_data(rd_data), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .err_clr(err_clr), .err_flag(err_flag));

   function automatic logic [15:0] init_val(int i);
      return {8'(i) ^ 8'hC3, 8'(i + 17)};
   endfunction

   // System-side register file model driven by the strobes
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
      end else if (wr_stb) begin
         stb_cnt   <= stb_cnt + 1;
         last_addr <= wr_addr;
         last_data <= wr_data;
         if (int'(wr_addr >> 1) < NREG) begin
            if (wr_addr[0]) mem[wr_addr >> 1][15:8] <= wr_data;
            else            mem[wr_addr >> 1][7:0]  <= wr_data;
         end
      end
   end

   assign rd_data = (int'(rd_idx) < NREG) ? mem[rd_idx] : 16'h0000;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] pat, input int nclk,
                       output logic [31:0] rx);
      rx = '0;
      spi_cs_n = 1'b0;
      #40;
      for (int i = nclk - 1; i >= 0; i--) begin
         spi_sclk = 1'b0;
         spi_din  = pat[i];
         #40;
         rx[i] = spi_dout;
         spi_sclk = 1'b1;
         #40;
      end
      #40;
      spi_cs_n = 1'b1;
      #120;
   endtask

   task automatic t_reset();
      chk("R11 err after reset", 32'(err_flag), 0);
      chk("R11 no strobe after reset", stb_cnt, 0);
      chk("R5 dout idle z", {31'b0, spi_dout}, {31'b0, 1'bz});
      xfer(32'h0400, 16, got);             // read byte 0x04
      chk("R11 first frame zeros", got[15:0], 0);
   endtask

   task automatic t_read_pair();
      xfer(32'h0500, 16, got);             // read byte 0x05 (odd)
      chk("R3 read data next frame", got[15:0], init_val(2));
      xfer(32'h0000, 16, got);             // read byte 0x00
      chk("R2 odd address same word", got[15:0], init_val(2));
      chk("R5 dout z between frames", {31'b0, spi_dout}, {31'b0, 1'bz});
   endtask

   task automatic t_write();
      int s0 = stb_cnt;
      xfer(32'h84A5, 16, got);             // write 0xA5 to byte 0x04
      chk("R3 read of reg0", got[15:0], init_val(0));
      chk("R1 one strobe", stb_cnt - s0, 1);
      chk("R1 strobe addr", 32'(last_addr), 32'h04);
      chk("R1 strobe data", 32'(last_data), 32'hA5);
      xfer(32'h0500, 16, got);
      chk("R4 zeros after write", got[15:0], 0);
      xfer(32'h853C, 16, got);             // write 0x3C to byte 0x05
      chk("R2 low byte updated", got[15:0], {init_val(2)[15:8], 8'hA5});
      chk("R1 high byte addr", 32'(last_addr), 32'h05);
      xfer(32'h0400, 16, got);
      xfer(32'h0000, 16, got);
      chk("R2 both bytes", got[15:0], 16'h3CA5);
   endtask

   task automatic t_bad();
      int s0 = stb_cnt;
      xfer(32'h0921, 12, got);             // 12 clocks, would be a write
      chk("R7 err set", 32'(err_flag), 1);
      chk("R8 no strobe on bad frame", stb_cnt - s0, 0);
      xfer(32'h0000, 16, got);
      chk("R8 pending read dropped", got[15:0], 0);
      chk("R7 err sticky", 32'(err_flag), 1);
      @(posedge clk); err_clr <= 1'b1;
      @(posedge clk); err_clr <= 1'b0;
      @(negedge clk);
      chk("R7 err cleared", 32'(err_flag), 0);
   endtask

   task automatic t_long();
      int s0 = stb_cnt;
      xfer(32'h8A33_8C77, 32, got);
      chk("R9 one strobe for 32 clocks", stb_cnt - s0, 1);
      chk("R9 last half addr", 32'(last_addr), 32'h0C);
      chk("R9 last half data", 32'(last_data), 32'h77);
      chk("R9 no err", 32'(err_flag), 0);
   endtask

   task automatic t_unmapped();
      int s0 = stb_cnt;
      xfer(32'hF055, 16, got);             // write byte 0x70
      chk("R10 no strobe unmapped", stb_cnt - s0, 0);
      xfer(32'h7000, 16, got);             // read byte 0x70
      xfer(32'h0000, 16, got);
      chk("R10 unmapped reads zero", got[15:0], 0);
   endtask

   task automatic t_empty();
      int s0;
      xfer(32'h0C00, 16, got);             // read byte 0x0C
      s0 = stb_cnt;
      spi_cs_n = 1'b0; #200; spi_cs_n = 1'b1; #120;
      chk("R12 no strobe", stb_cnt - s0, 0);
      chk("R12 no err", 32'(err_flag), 0);
      xfer(32'h0000, 16, got);
      chk("R12 pending read kept", got[15:0], {init_val(6)[15:8], 8'h77});
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      t_reset();
      t_read_pair();
      t_write();
      t_bad();
      t_long();
      t_unmapped();
      t_empty();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule